// File: doc/BRIEF.md
# Display Enable Glitch Filter

This block cleans up a raw display-enable flag that a video timing engine produces. The flag is only meaningful once per video field, so the filter looks at it only when a field strobe is present. A short drop of the enable must not blank the screen. The filter therefore treats the two directions differently.

A rising enable is accepted on the field where it appears. It also issues a one-cycle full-refresh request so that downstream rendering redraws the whole picture. A falling enable starts a hold-off of `HOLD_FIELDS` fields, and the filtered output stays active for that time. If the raw level changes again before the hold-off runs out, the hold-off is abandoned and the new level is adopted at once. This absorbs brief drop-outs without a redraw.

The filtered level drives the display path's blanking decision. The refresh pulse triggers a full redraw.

Top module: `dispen_glitch_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the filtered output and the refresh pulse are both 0, whatever the raw level was before the reset.
- R2: The raw level is evaluated only in cycles where the field strobe is 1. Changing the raw level in other cycles leaves both outputs unchanged, and the refresh pulse stays 0.
- R3: A field strobe that sees the raw level at 1, while the filtered output is 0, makes the filtered output 1 in the next cycle. The same cycle carries a refresh pulse.
- R4: The refresh pulse is 1 for exactly one cycle. That cycle is the one right after a field strobe.
- R5: When a field strobe sees the raw level fall from 1 to 0 with no hold-off pending, the filtered output stays 1. It goes to 0 only after the HOLD_FIELDS-th following strobe that still sees 0 (default HOLD_FIELDS = 2). No refresh pulse is raised for this fall.
- R6: A strobe that sees the raw level back at 1 while a hold-off is pending cancels the hold-off. The output stays 1 and no refresh pulse is raised. A later fall starts a fresh, full-length hold-off.
- R7: Field strobes that keep seeing an unchanged raw level of 1 raise no further refresh pulses.
- R8: While a hold-off is pending, the filtered output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| field_stb_i | input | 1 | One-cycle strobe marking a field boundary |
| raw_en_i | input | 1 | Unfiltered display-enable level |
| disp_active_o | output | 1 | Filtered display-active level |
| refresh_o | output | 1 | One-cycle full-refresh request |

## Verification
Both outputs come from registers that update on the clock edge where the field strobe is high. Each result is therefore due exactly one cycle after the strobe, and the bench samples it at the falling edge that follows that clock edge. Inputs are driven at falling edges, and each strobe lasts exactly one cycle. Between strobes the bench flips the raw level and waits two further cycles, then checks that neither output moved. This separates the field-gated behaviour from any combinational leak.

// File: rtl/dispen_filt_pkg.sv
package dispen_filt_pkg;

    typedef enum logic [1:0] {
        HOLD_KEEP  = 2'd0,
        HOLD_LOAD  = 2'd1,
        HOLD_CLEAR = 2'd2,
        HOLD_STEP  = 2'd3
    } hold_cmd_e;

    typedef struct packed {
        logic seen;     // last raw level observed at a field strobe
        logic shown;    // filtered level presented at the output
        logic refresh;  // full-refresh request, one cycle
    } filt_state_t;

endpackage

// File: rtl/dispen_holdoff_cnt.sv
module dispen_holdoff_cnt
    import dispen_filt_pkg::*;
#(
    parameter int HOLD_FIELDS = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  hold_cmd_e cmd_i,
    output logic      busy_o,
    output logic      last_o
);

    localparam int CW = $clog2(HOLD_FIELDS + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_FIELDS);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (cmd_i)
            HOLD_LOAD:  cnt_d = LOAD_VAL;
            HOLD_CLEAR: cnt_d = '0;
            HOLD_STEP:  if (cnt_q != '0) cnt_d = cnt_q - ONE;
            default:    cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == ONE);

endmodule

// File: rtl/dispen_filt_core.sv
module dispen_filt_core
    import dispen_filt_pkg::*;
(
    input  logic        field_stb_i,
    input  logic        raw_en_i,
    input  filt_state_t state_q_i,
    input  logic        hold_busy_i,
    input  logic        hold_last_i,
    output filt_state_t state_d_o,
    output hold_cmd_e   hold_cmd_o
);

    logic level_changed;

    assign level_changed = (raw_en_i != state_q_i.seen);

    always_comb begin
        state_d_o         = state_q_i;
        state_d_o.refresh = 1'b0;
        hold_cmd_o        = HOLD_KEEP;

        if (field_stb_i) begin
            if (level_changed && hold_busy_i) begin
                // a second change during hold-off: drop the countdown
                hold_cmd_o      = HOLD_CLEAR;
                state_d_o.seen  = raw_en_i;
                state_d_o.shown = raw_en_i;
            end else if (level_changed && raw_en_i) begin
                // activation is immediate and asks for a redraw
                state_d_o.seen    = 1'b1;
                state_d_o.shown   = 1'b1;
                state_d_o.refresh = 1'b1;
            end else if (level_changed) begin
                // deactivation: keep the shown level, start the hold-off
                hold_cmd_o      = HOLD_LOAD;
                state_d_o.seen  = 1'b0;
                state_d_o.shown = state_q_i.seen;
            end else if (hold_busy_i) begin
                hold_cmd_o = HOLD_STEP;
                if (hold_last_i) begin
                    state_d_o.shown   = state_q_i.seen;
                    state_d_o.refresh = state_q_i.seen;
                end
            end
        end
    end

endmodule

// File: rtl/dispen_glitch_filter.sv
module dispen_glitch_filter
    import dispen_filt_pkg::*;
#(
    parameter int HOLD_FIELDS = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic field_stb_i,
    input  logic raw_en_i,
    output logic disp_active_o,
    output logic refresh_o
);

    filt_state_t state_d, state_q;
    hold_cmd_e   hold_cmd;
    logic        hold_busy;
    logic        hold_last;

    dispen_filt_core u_core (
        .field_stb_i (field_stb_i),
        .raw_en_i    (raw_en_i),
        .state_q_i   (state_q),
        .hold_busy_i (hold_busy),
        .hold_last_i (hold_last),
        .state_d_o   (state_d),
        .hold_cmd_o  (hold_cmd)
    );

    dispen_holdoff_cnt #(
        .HOLD_FIELDS (HOLD_FIELDS)
    ) u_hold (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cmd_i  (hold_cmd),
        .busy_o (hold_busy),
        .last_o (hold_last)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign disp_active_o = state_q.shown;
    assign refresh_o     = state_q.refresh;

endmodule

// File: rtl/dispen_filt_chk.sv
module dispen_filt_chk (
    input logic clk_i,
    input logic rst_i,
    input logic field_stb_i,
    input logic raw_en_i,
    input logic disp_active_o,
    input logic refresh_o,
    input logic hold_busy
);

    // R4: the refresh request never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        refresh_o |=> !refresh_o);

    // R4: the refresh request only follows a field strobe
    a_r4_after_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        refresh_o |-> $past(field_stb_i));

    // R2: no output movement without a strobe in the previous cycle
    a_r2_gated: assert property (@(posedge clk_i) disable iff (rst_i)
        !field_stb_i |=> ($stable(disp_active_o) && !refresh_o));

    // R3: a strobe that sees the enable high leaves the output active
    a_r3_rise_now: assert property (@(posedge clk_i) disable iff (rst_i)
        (field_stb_i && raw_en_i) |=> disp_active_o);

    // R3: every activation carries a refresh request
    a_r3_rise_refresh: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(disp_active_o) |-> refresh_o);

    // R8: a pending hold-off keeps the output active
    a_r8_hold_active: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_busy |-> disp_active_o);

endmodule

bind dispen_glitch_filter dispen_filt_chk u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .field_stb_i   (field_stb_i),
    .raw_en_i      (raw_en_i),
    .disp_active_o (disp_active_o),
    .refresh_o     (refresh_o),
    .hold_busy     (hold_busy)
);

// File: tb/dispen_glitch_filter_bench.sv
module dispen_glitch_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // each entry: {raw level at the strobe, expected active, expected refresh}
    localparam logic [2:0] VEC [NVEC] = '{
        3'b000,  // 0  idle low                          R2
        3'b111,  // 1  rise, immediate with refresh      R3
        3'b110,  // 2  steady high, no new refresh       R7
        3'b010,  // 3  fall, held                        R5
        3'b010,  // 4  still held                        R5
        3'b000,  // 5  hold-off expires                  R5
        3'b000,  // 6  stays low
        3'b111,  // 7  rise again                        R3
        3'b010,  // 8  fall, held
        3'b110,  // 9  rise during hold-off, cancel      R6
        3'b110,  // 10 steady
        3'b010,  // 11 fall, fresh hold-off              R6
        3'b010,  // 12 held
        3'b110,  // 13 rise on last held field, cancel   R6
        3'b010,  // 14 fall, fresh full hold-off         R6
        3'b010,  // 15 held
        3'b000   // 16 expires after full length         R6
    };

    logic clk = 1'b0;
    logic rst;
    logic field_stb;
    logic raw_en;
    logic disp_active;
    logic refresh;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispen_glitch_filter u_dispen_glitch_filter (
        .clk_i         (clk),
        .rst_i         (rst),
        .field_stb_i   (field_stb),
        .raw_en_i      (raw_en),
        .disp_active_o (disp_active),
        .refresh_o     (refresh)
    );

    task automatic check_bit(input string tag, input logic actual, input logic expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, actual, expected, $time);
        end
    endtask

    // one strobe with the given raw level; sample one cycle later
    task automatic field(input logic lvl, input logic exp_act, input logic exp_ref, input string tag);
        raw_en    = lvl;
        field_stb = 1'b1;
        @(negedge clk);
        field_stb = 1'b0;
        check_bit({tag, " active"},  disp_active, exp_act);
        check_bit({tag, " refresh"}, refresh,     exp_ref);
    endtask

    // flip raw between strobes and confirm nothing moves (R2, R4)
    task automatic idle_flip(input logic exp_act);
        raw_en = ~raw_en;
        @(negedge clk);
        check_bit("R4 pulse width", refresh, 1'b0);
        @(negedge clk);
        check_bit("R2 no strobe active", disp_active, exp_act);
        check_bit("R2 no strobe refresh", refresh, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst       = 1'b1;
        field_stb = 1'b0;
        raw_en    = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R1 reset active", disp_active, 1'b0);
        check_bit("R1 reset refresh", refresh, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 after reset active", disp_active, 1'b0);
        check_bit("R1 after reset refresh", refresh, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            field(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("vec%0d R3/R5/R6/R7", i));
            idle_flip(VEC[i][1]);
        end

        // R1: reset in the middle of a hold-off
        field(1'b1, 1'b1, 1'b1, "R3 pre-reset rise");
        field(1'b0, 1'b1, 1'b0, "R5 pre-reset fall");
        rst = 1'b1;
        @(negedge clk);
        check_bit("R1 mid hold-off active", disp_active, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 no refresh after reset", refresh, 1'b0);
        field(1'b0, 1'b0, 1'b0, "R1 counter cleared");
        field(1'b1, 1'b1, 1'b1, "R3 rise after reset");
        field(1'b1, 1'b1, 1'b0, "R7 steady after reset");

        // R4: back-to-back strobes still give a single pulse
        field(1'b0, 1'b1, 1'b0, "R5 fall b2b");
        field(1'b1, 1'b1, 1'b0, "R6 cancel b2b");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule